// File: doc/BRIEF.md
# Dual-Line Ping-Pong Calibration Scheduler

This block keeps two identical tapped-delay-line time converters busy without a gap in measurement. At any moment one line is being calibrated while the other converts live start/stop events. A free-running period counter swaps the two roles at a fixed interval. The block routes the two signal pairs to the lines with cross-wired multiplexers. It issues a start pulse to the calibration engine of the line that is calibrating, and it watches that engine's done flag. Each line has its own calibration table, which its engine writes. The outgoing code is the converting line's raw bin index, looked up in that line's table.

The role period is `2^CLR_LOG + 2^CNT_LOG + 2^CLR_LOG` cycles. This covers a table clear, a code-density count and an accumulate pass. With the default values and a 6 ns clock, one period lasts about 0.8 ms, so each line is refreshed every 1.6 ms. An engine that fails to finish inside its period does not cause a swap to its unfinished table. The converting line keeps its good table, and the late line starts its calibration again.

Top module: `pingpong_cal_sched`

## Requirements
- R1: After reset line A calibrates (`cal_line_b` = 0) and the period counter is at 0. A role swap only happens on the clock edge that closes a period of P = 2^CLR_LOG + 2^CNT_LOG + 2^CLR_LOG cycles.
- R2: While line A calibrates, `cal_src_start`/`cal_src_stop` drive `line_a_start`/`line_a_stop`, and `trig_start`/`trig_stop` drive `line_b_start`/`line_b_stop`.
- R3: While line B calibrates, the routing is mirrored: the calibration sources drive line B and the triggers drive line A.
- R4: `eng_go_a` or `eng_go_b` (only the one for the calibrating line) is high for exactly the first cycle of each period. The other go output stays low.
- R5: `code_out` is the converting line's table word at the raw bin index that line presented at the previous clock edge (one cycle of latency). `cal_line_b` = 1 means line A is converting.
- R6: A table write (`tbl_we_x`, address, data) takes effect at the clock edge. A read at the same edge returns the old word, and reads at later edges return the new word.
- R7: `code_valid` is low until the converting line has completed at least one calibration since reset.
- R8: `code_valid` is low in the first cycle after a role swap.
- R9: If the calibrating engine's done flag is never high during a period, including its last cycle, then in the first cycle of the next period `cal_timeout` is high for one cycle, the roles do not swap, and a new go pulse restarts the same line.
- R10: The done flag of the engine whose line is converting has no effect on swaps or timeouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_start | input | 1 | Measurement start trigger |
| trig_stop | input | 1 | Measurement stop trigger |
| cal_src_start | input | 1 | Calibration start source |
| cal_src_stop | input | 1 | Calibration stop source |
| raw_bin_a | input | BIN_W | Raw bin index from line A encoder |
| raw_bin_b | input | BIN_W | Raw bin index from line B encoder |
| eng_done_a | input | 1 | Calibration engine A finished |
| eng_done_b | input | 1 | Calibration engine B finished |
| tbl_we_a | input | 1 | Table A write enable (from engine A) |
| tbl_waddr_a | input | BIN_W | Table A write address |
| tbl_wdata_a | input | CODE_W | Table A write data |
| tbl_we_b | input | 1 | Table B write enable (from engine B) |
| tbl_waddr_b | input | BIN_W | Table B write address |
| tbl_wdata_b | input | CODE_W | Table B write data |
| line_a_start | output | 1 | Start input of line A |
| line_a_stop | output | 1 | Stop input of line A |
| line_b_start | output | 1 | Start input of line B |
| line_b_stop | output | 1 | Stop input of line B |
| eng_go_a | output | 1 | Start pulse to calibration engine A |
| eng_go_b | output | 1 | Start pulse to calibration engine B |
| cal_line_b | output | 1 | 1 when line B calibrates, 0 when line A does |
| code_out | output | CODE_W | Calibrated output code |
| code_valid | output | 1 | code_out is usable |
| cal_timeout | output | 1 | One-cycle flag: the calibrating engine missed its period |

## Verification
A wrong period count shows at the ports within one period: `cal_line_b` flips on the wrong edge, or the go pulse appears in the wrong cycle. A done flag that is latched wrongly, or taken from the wrong engine, shows up at the close of the affected period as a swap that should not happen or a missing `cal_timeout`. A stale or wrongly selected table shows as a `code_out` mismatch in the first valid cycle after it. An early `code_valid` is exposed in the cycle right after a swap, or during the first period, when the converting line has never been calibrated.

// File: rtl/pp_sched_pkg.sv
package pp_sched_pkg;
   typedef enum logic {LINE_A = 1'b0, LINE_B = 1'b1} line_e;

   // clear + count + accumulate phases of one calibration
   function automatic int unsigned role_period(input int unsigned clr_log,
                                               input int unsigned cnt_log);
      return ((32'd1 << clr_log) * 2) + (32'd1 << cnt_log);
   endfunction
endpackage

// File: rtl/pp_cal_table.sv
module pp_cal_table #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("pp_cal_table: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pp_cal_table: DATA_W must be positive");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem[raddr];
   end
endmodule

// File: rtl/pp_role_ctrl.sv
module pp_role_ctrl
   import pp_sched_pkg::*;
#(
   parameter int unsigned CLR_LOG = 9,
   parameter int unsigned CNT_LOG = 17
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done_a,
   input  logic       done_b,
   output line_e      role,
   output logic       go_a,
   output logic       go_b,
   output logic [1:0] calibrated,
   output logic       bubble,
   output logic       timeout
);
   localparam int unsigned PERIOD = role_period(CLR_LOG, CNT_LOG);
   localparam int CW = $clog2(PERIOD);

   if (CLR_LOG < 1 || CNT_LOG < 1 || CNT_LOG > 28) begin : g_bad_log
      $error("pp_role_ctrl: phase lengths out of range");
   end

   logic [CW-1:0] cnt;
   logic          seen;
   logic          at_end;
   logic          done_cur;
   logic          ok;

   assign at_end   = (cnt == CW'(PERIOD - 1));
   assign done_cur = (role == LINE_B) ? done_b : done_a;
   assign ok       = seen | done_cur;
   assign go_a     = (cnt == '0) && (role == LINE_A);
   assign go_b     = (cnt == '0) && (role == LINE_B);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         seen       <= 1'b0;
         role       <= LINE_A;
         calibrated <= 2'b00;
         bubble     <= 1'b0;
         timeout    <= 1'b0;
      end else begin
         cnt     <= at_end ? '0 : cnt + 1'b1;
         seen    <= at_end ? 1'b0 : ok;
         bubble  <= at_end & ok;
         timeout <= at_end & ~ok;
         if (at_end && ok) begin
            if (role == LINE_A) begin
               calibrated[0] <= 1'b1;
               role          <= LINE_B;
            end else begin
               calibrated[1] <= 1'b1;
               role          <= LINE_A;
            end
         end
      end
   end

   // R1
   swap_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (role != $past(role)) |-> ($past(cnt) == CW'(PERIOD - 1)));

   // R4
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (go_a | go_b) |=> !(go_a | go_b));

   // R9
   timeout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (role == $past(role)) && (cnt == '0));
endmodule

// File: rtl/pingpong_cal_sched.sv
module pingpong_cal_sched
   import pp_sched_pkg::*;
#(
   parameter int unsigned CLR_LOG = 9,
   parameter int unsigned CNT_LOG = 17,
   parameter int          BIN_W   = 9,
   parameter int          CODE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_start,
   input  logic              trig_stop,
   input  logic              cal_src_start,
   input  logic              cal_src_stop,
   input  logic [BIN_W-1:0]  raw_bin_a,
   input  logic [BIN_W-1:0]  raw_bin_b,
   input  logic              eng_done_a,
   input  logic              eng_done_b,
   input  logic              tbl_we_a,
   input  logic [BIN_W-1:0]  tbl_waddr_a,
   input  logic [CODE_W-1:0] tbl_wdata_a,
   input  logic              tbl_we_b,
   input  logic [BIN_W-1:0]  tbl_waddr_b,
   input  logic [CODE_W-1:0] tbl_wdata_b,
   output logic              line_a_start,
   output logic              line_a_stop,
   output logic              line_b_start,
   output logic              line_b_stop,
   output logic              eng_go_a,
   output logic              eng_go_b,
   output logic              cal_line_b,
   output logic [CODE_W-1:0] code_out,
   output logic              code_valid,
   output logic              cal_timeout
);
   localparam int NLINES = 2;

   line_e       role;
   logic [1:0]  calibrated;
   logic        bubble;

   logic              we_v    [NLINES];
   logic [BIN_W-1:0]  waddr_v [NLINES];
   logic [CODE_W-1:0] wdata_v [NLINES];
   logic [BIN_W-1:0]  raddr_v [NLINES];
   logic [CODE_W-1:0] rd_v    [NLINES];

   assign we_v[0]    = tbl_we_a;
   assign we_v[1]    = tbl_we_b;
   assign waddr_v[0] = tbl_waddr_a;
   assign waddr_v[1] = tbl_waddr_b;
   assign wdata_v[0] = tbl_wdata_a;
   assign wdata_v[1] = tbl_wdata_b;
   assign raddr_v[0] = raw_bin_a;
   assign raddr_v[1] = raw_bin_b;

   pp_role_ctrl #(.CLR_LOG(CLR_LOG), .CNT_LOG(CNT_LOG)) u_role (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_a     (eng_done_a),
      .done_b     (eng_done_b),
      .role       (role),
      .go_a       (eng_go_a),
      .go_b       (eng_go_b),
      .calibrated (calibrated),
      .bubble     (bubble),
      .timeout    (cal_timeout)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_tbl
      pp_cal_table #(.ADDR_W(BIN_W), .DATA_W(CODE_W)) u_tbl (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we_v[i]),
         .waddr (waddr_v[i]),
         .wdata (wdata_v[i]),
         .raddr (raddr_v[i]),
         .rdata (rd_v[i])
      );
   end

   // cross-wired routing: calibrating line sees the calibration sources
   assign cal_line_b   = (role == LINE_B);
   assign line_a_start = cal_line_b ? trig_start    : cal_src_start;
   assign line_a_stop  = cal_line_b ? trig_stop     : cal_src_stop;
   assign line_b_start = cal_line_b ? cal_src_start : trig_start;
   assign line_b_stop  = cal_line_b ? cal_src_stop  : trig_stop;

   // output comes from the converting line's own table
   assign code_out   = cal_line_b ? rd_v[0] : rd_v[1];
   assign code_valid = (cal_line_b ? calibrated[0] : calibrated[1]) & ~bubble;

   // R8
   swap_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_line_b != $past(cal_line_b)) |-> !code_valid);
endmodule

// File: tb/pingpong_cal_sched_test.sv
module pingpong_cal_sched_test;
   localparam int CLR = 2;
   localparam int CNT = 3;
   localparam int P   = 2 * (1 << CLR) + (1 << CNT);
   localparam int BW  = 4;
   localparam int CW  = 8;
   localparam int NB  = 1 << BW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trig_start = 0, trig_stop = 0, cal_src_start = 0, cal_src_stop = 0;
   logic [BW-1:0] raw_bin_a = '0, raw_bin_b = '0;
   logic eng_done_a = 0, eng_done_b = 0;
   logic tbl_we_a = 0, tbl_we_b = 0;
   logic [BW-1:0] tbl_waddr_a = '0, tbl_waddr_b = '0;
   logic [CW-1:0] tbl_wdata_a = '0, tbl_wdata_b = '0;
   logic line_a_start, line_a_stop, line_b_start, line_b_stop;
   logic eng_go_a, eng_go_b, cal_line_b, code_valid, cal_timeout;
   logic [CW-1:0] code_out;

   always #4 clk = ~clk;

   pingpong_cal_sched #(.CLR_LOG(CLR), .CNT_LOG(CNT), .BIN_W(BW), .CODE_W(CW)) uut (
      .clk(clk), .rst_n(rst_n),
      .trig_start(trig_start), .trig_stop(trig_stop),
      .cal_src_start(cal_src_start), .cal_src_stop(cal_src_stop),
      .raw_bin_a(raw_bin_a), .raw_bin_b(raw_bin_b),
      .eng_done_a(eng_done_a), .eng_done_b(eng_done_b),
      .tbl_we_a(tbl_we_a), .tbl_waddr_a(tbl_waddr_a), .tbl_wdata_a(tbl_wdata_a),
      .tbl_we_b(tbl_we_b), .tbl_waddr_b(tbl_waddr_b), .tbl_wdata_b(tbl_wdata_b),
      .line_a_start(line_a_start), .line_a_stop(line_a_stop),
      .line_b_start(line_b_start), .line_b_stop(line_b_stop),
      .eng_go_a(eng_go_a), .eng_go_b(eng_go_b), .cal_line_b(cal_line_b),
      .code_out(code_out), .code_valid(code_valid), .cal_timeout(cal_timeout));

   int checks = 0, errors = 0;

   // behavioural reference state
   int m_cnt, m_role, m_seen, m_bubble, m_tmo, n_swaps, n_tmo, n_valid;
   bit m_cal [2];
   logic [CW-1:0] ta [NB];
   logic [CW-1:0] tb [NB];
   logic [CW-1:0] m_rd_a, m_rd_b;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_role = 0; m_seen = 0; m_bubble = 0; m_tmo = 0;
         m_cal[0] = 0; m_cal[1] = 0; m_rd_a = '0; m_rd_b = '0;
      end else begin
         logic [CW-1:0] na, nb;
         bit fin, dcur, ok;
         na = ta[raw_bin_a];
         nb = tb[raw_bin_b];
         if (tbl_we_a) ta[tbl_waddr_a] = tbl_wdata_a;
         if (tbl_we_b) tb[tbl_waddr_b] = tbl_wdata_b;
         fin  = (m_cnt == P - 1);
         dcur = (m_role == 1) ? eng_done_b : eng_done_a;
         ok   = (m_seen != 0) || dcur;
         m_tmo    = fin && !ok;
         m_bubble = fin && ok;
         if (m_tmo) n_tmo++;
         if (fin && ok) begin
            m_cal[m_role] = 1;
            m_role = 1 - m_role;
            n_swaps++;
         end
         m_seen = fin ? 0 : int'(ok);
         m_cnt  = fin ? 0 : m_cnt + 1;
         m_rd_a = na;
         m_rd_b = nb;
      end
   end

   task automatic compare_all();
      bit ev, ea, eb;
      logic [CW-1:0] ec;
      // R1 role output
      chk(cal_line_b == m_role[0], "R1 role", cal_line_b, m_role);
      // R2 / R3 routing
      ea = (m_role == 0) ? cal_src_start : trig_start;
      eb = (m_role == 0) ? trig_start : cal_src_start;
      chk(line_a_start == ea && line_b_start == eb, m_role == 0 ? "R2 start route" : "R3 start route",
          {line_a_start, line_b_start}, {ea, eb});
      ea = (m_role == 0) ? cal_src_stop : trig_stop;
      eb = (m_role == 0) ? trig_stop : cal_src_stop;
      chk(line_a_stop == ea && line_b_stop == eb, m_role == 0 ? "R2 stop route" : "R3 stop route",
          {line_a_stop, line_b_stop}, {ea, eb});
      // R4 go pulses
      chk(eng_go_a == (m_cnt == 0 && m_role == 0) && eng_go_b == (m_cnt == 0 && m_role == 1),
          "R4 go", {eng_go_a, eng_go_b}, {(m_cnt == 0 && m_role == 0), (m_cnt == 0 && m_role == 1)});
      // R9 / R10 timeout
      chk(cal_timeout == m_tmo[0], "R9 R10 timeout", cal_timeout, m_tmo);
      // R7 / R8 validity
      ev = m_cal[1 - m_role] && (m_bubble == 0);
      chk(code_valid == ev, m_bubble != 0 ? "R8 valid" : "R7 valid", code_valid, ev);
      // R5 / R6 code
      if (ev) begin
         ec = (m_role == 1) ? m_rd_a : m_rd_b;
         n_valid++;
         chk(code_out === ec, "R5 R6 code", code_out, ec);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int cyc;
      bit block;
      n_swaps = 0; n_tmo = 0; n_valid = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 R7 reset state while held
      chk(cal_line_b == 0 && code_valid == 0 && cal_timeout == 0, "R1 R7 in reset",
          {cal_line_b, code_valid, cal_timeout}, 0);
      rst_n = 1'b1;
      #1;
      chk(eng_go_a == 1 && eng_go_b == 0, "R4 first go after reset", {eng_go_a, eng_go_b}, 2);
      for (cyc = 0; cyc < 900; cyc++) begin
         compare_all();
         // next stimulus
         block = (cyc >= 300 && cyc < 340) || (cyc >= 600 && cyc < 620);
         trig_start    = $urandom % 2;
         trig_stop     = $urandom % 2;
         cal_src_start = $urandom % 2;
         cal_src_stop  = $urandom % 2;
         raw_bin_a     = BW'($urandom);
         raw_bin_b     = BW'($urandom);
         // R10: the converting engine's done toggles freely
         if (block) begin
            eng_done_a = (m_role == 1) ? ($urandom % 2) : 1'b0;
            eng_done_b = (m_role == 0) ? ($urandom % 2) : 1'b0;
         end else begin
            eng_done_a = ($urandom % 4) == 0;
            eng_done_b = ($urandom % 4) == 0;
         end
         if (cyc < NB) begin
            tbl_we_a = 1; tbl_waddr_a = BW'(cyc);
            tbl_we_b = 1; tbl_waddr_b = BW'(cyc);
         end else begin
            tbl_we_a = $urandom % 2; tbl_waddr_a = BW'($urandom);
            tbl_we_b = $urandom % 2; tbl_waddr_b = BW'($urandom);
         end
         tbl_wdata_a = CW'($urandom);
         tbl_wdata_b = CW'($urandom);
         @(negedge clk);
      end
      // coverage of the scenarios the requirements describe
      chk(n_swaps >= 4, "R1 swaps observed", n_swaps, 4);
      chk(n_tmo >= 1, "R9 timeouts observed", n_tmo, 1);
      chk(n_valid >= 100, "R5 valid codes observed", n_valid, 100);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule